// File: doc/BRIEF.md
# Three-Level Page-Table Walker

This block resolves a 39-bit virtual address to a 56-bit physical address by walking a three-level radix page table held in memory. A request carries the virtual address, the kind of access, the privilege of the requester, two relaxation flags and the page number of the root table. The walker then reads one 8-byte entry per level over a plain request/response memory port. It follows pointer entries downward until it reaches a leaf, then checks that leaf and reports either a translation or an error code.

Leaves found above the last level map large pages. The walker checks that such a page is aligned and then builds the address from the page number of the leaf and the lower index bits of the virtual address. When the leaf still has its accessed bit clear, or a store finds its dirty bit clear, the walker either fails or writes the updated entry back, depending on an enable input. The global attribute is gathered along the whole path. A caching layer and the mapping of error codes to exceptions sit outside this block.

Top module: `pt_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req_valid` are low, and the walker stays idle with no memory request until `start` is seen.
- R2: The first read goes to `root_ppn<<12 + 8*VA[38:30]`. A pointer entry (bits R=1, W=2 and X=3 all clear) gives the next base `PPN<<12`, where PPN is entry bits 53:10. The next read indexes that base with `VA[29:21]` and then `VA[20:12]`. The level is reported as 2, 1 or 0.
- R3: At most one memory request is outstanding. While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, write flag and data hold steady.
- R4: An error response to an entry read ends the walk with code 1 (access).
- R5: An entry with V (bit 0) clear, an entry with W set and R clear, or a pointer entry at level 0 ends the walk with code 2 (invalid).
- R6: A leaf fails with code 3 (no permission) under these rules. Access is coded 0 read, 1 write, 2 read-write, 3 execute, and U is bit 4. A readable leaf has R set, or has X set while `mxr` is high. A user access needs U set. A supervisor data access needs U clear or `sum` high. A supervisor execute access needs U clear. Read needs a readable leaf, write needs W, read-write needs both, and execute needs X.
- R7: A leaf at level L>0 whose low 9·L PPN bits are not all zero fails with code 4 (misaligned). The permission check takes priority over this check.
- R8: On success `paddr` is the leaf PPN with its low 9·L bits taken from the matching VPN bits, followed by `VA[11:0]`. The outputs `leaf_pte`, `leaf_addr` and `leaf_lvl` describe the leaf.
- R9: `global` is the OR of the G bits (bit 5) of every entry read during the walk.
- R10: If the leaf has A (bit 6) clear, or the access is a write or read-write and D (bit 7) is clear, while `upd_en` is low, the walk fails with code 5 and no write is issued.
- R11: In the case of R10 with `upd_en` high, the entry with A set (and D set for write or read-write) is written to `leaf_addr` before success is reported. `leaf_pte` shows the written value. A leaf that needs no update causes no write.
- R12: An error response to the write-back ends the walk with code 1.
- R13: `done` is a one-cycle pulse. `ok` is high exactly when `err_code` is 0. A `start` seen while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (sampled while idle) |
| vaddr | input | 39 | Virtual address |
| acc | input | 2 | Access kind: 0 read, 1 write, 2 read-write, 3 execute |
| user | input | 1 | 1 = user privilege, 0 = supervisor |
| mxr | input | 1 | Executable leaves count as readable |
| sum | input | 1 | Supervisor may touch user pages with data accesses |
| upd_en | input | 1 | Allow accessed/dirty write-back |
| root_ppn | input | 44 | Page number of the root table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 56 | Byte address of the 8-byte entry |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Walk succeeded |
| err_code | output | 3 | 0 none, 1 access, 2 invalid, 3 permission, 4 misaligned, 5 update needed |
| paddr | output | 56 | Translated physical address |
| leaf_pte | output | 64 | Leaf entry (as written back if updated) |
| leaf_addr | output | 56 | Address of the leaf entry |
| leaf_lvl | output | 2 | Level of the leaf |
| global | output | 1 | OR of G bits along the walk |

## Verification
The bench builds the walker with its default parameters: three levels of 9 index bits, 4 KiB pages, 56-bit physical addresses and 64-bit entries. With these values, leaves at all three levels can be placed in a sparse memory model that spans the real 56-bit space. The tests cover 4 KiB pages, 2 MiB pages and 1 GiB pages, with aligned and misaligned page numbers. Error injection on single addresses lets the bench fail the read of an entry and the write-back of a leaf separately.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int LEVELS = 3,
  parameter int IDX_W  = 9,
  parameter int PG_W   = 12,
  parameter int PPN_W  = 44,
  parameter int PTE_W  = 64,
  parameter int LVL_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [PG_W+LEVELS*IDX_W-1:0] vaddr,
  input  logic [1:0]             acc,
  input  logic                   user,
  input  logic                   mxr,
  input  logic                   sum,
  input  logic                   upd_en,
  input  logic [PPN_W-1:0]       root_ppn,
  output logic                   busy,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic                   mem_req_we,
  output logic [PPN_W+PG_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0]       mem_req_wdata,
  input  logic                   mem_rsp_valid,
  input  logic                   mem_rsp_err,
  input  logic [PTE_W-1:0]       mem_rsp_data,
  output logic                   done,
  output logic                   ok,
  output logic [2:0]             err_code,
  output logic [PPN_W+PG_W-1:0]  paddr,
  output logic [PTE_W-1:0]       leaf_pte,
  output logic [PPN_W+PG_W-1:0]  leaf_addr,
  output logic [LVL_W-1:0]       leaf_lvl,
  output logic                   global
);
  localparam int VA_W   = PG_W + LEVELS*IDX_W;
  localparam int PA_W   = PPN_W + PG_W;
  localparam int PPN_LO = 10;

  localparam logic [2:0] E_NONE = 3'd0, E_ACC = 3'd1, E_INV = 3'd2,
                         E_PERM = 3'd3, E_MIS = 3'd4, E_UPD = 3'd5;
  localparam logic [1:0] A_RD = 2'd0, A_WR = 2'd1, A_RW = 2'd2, A_EX = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RDW, S_WB, S_WBW} st_t;
  st_t st;

  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q, mxr_q, sum_q, upd_q, glob_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q;

  wire [7:0]       at    = mem_rsp_data[7:0];
  wire [PPN_W-1:0] ppn   = mem_rsp_data[PPN_LO +: PPN_W];
  wire [IDX_W-1:0] idx   = va_q[PG_W + 32'(lvl_q)*IDX_W +: IDX_W];
  wire [PA_W-1:0]  raddr = base_q + (PA_W'(idx) << 3);
  wire [PPN_W-1:0] lmask = ~({PPN_W{1'b1}} << (32'(lvl_q) * IDX_W));
  wire [PPN_W-1:0] vpn   = PPN_W'(va_q[VA_W-1:PG_W]);

  wire is_inv  = !at[0] || (at[2] && !at[1]);
  wire is_ptr  = !at[1] && !at[2] && !at[3];
  wire rd_ok   = at[1] || (at[3] && mxr_q);
  wire su_ok   = !at[4] || sum_q;
  wire misal   = (lvl_q != '0) && |(ppn & lmask);
  wire need_d  = (acc_q == A_WR || acc_q == A_RW) && !at[7];
  wire need    = need_d || !at[6];
  wire glob_n  = glob_q || at[5];

  logic perm_ok;
  always_comb begin
    case (acc_q)
      A_RD:    perm_ok = rd_ok;
      A_WR:    perm_ok = at[2];
      A_RW:    perm_ok = at[2] && rd_ok;
      default: perm_ok = at[3];
    endcase
    if (user_q) perm_ok = perm_ok && at[4];
    else if (acc_q == A_EX) perm_ok = perm_ok && !at[4];
    else perm_ok = perm_ok && su_ok;
  end

  logic [2:0] rcode;
  always_comb begin
    if (mem_rsp_err)                    rcode = E_ACC;
    else if (is_inv)                    rcode = E_INV;
    else if (is_ptr && lvl_q == '0)     rcode = E_INV;
    else if (is_ptr)                    rcode = E_NONE;
    else if (!perm_ok)                  rcode = E_PERM;
    else if (misal)                     rcode = E_MIS;
    else if (need && !upd_q)            rcode = E_UPD;
    else                                rcode = E_NONE;
  end
  wire descend = !mem_rsp_err && !is_inv && is_ptr && lvl_q != '0;

  assign busy          = st != S_IDLE;
  assign mem_req_valid = st == S_RD || st == S_WB;
  assign mem_req_we    = st == S_WB;
  assign mem_req_addr  = (st == S_WB) ? leaf_addr : raddr;
  assign mem_req_wdata = leaf_pte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0; acc_q <= '0; user_q <= 1'b0; mxr_q <= 1'b0; sum_q <= 1'b0;
      upd_q <= 1'b0; glob_q <= 1'b0; lvl_q <= '0; base_q <= '0;
      done <= 1'b0; ok <= 1'b0; err_code <= E_NONE;
      paddr <= '0; leaf_pte <= '0; leaf_addr <= '0; leaf_lvl <= '0; global <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          va_q <= vaddr; acc_q <= acc; user_q <= user; mxr_q <= mxr;
          sum_q <= sum; upd_q <= upd_en; glob_q <= 1'b0;
          lvl_q <= LVL_W'(LEVELS-1);
          base_q <= PA_W'(root_ppn) << PG_W;
          st <= S_RD;
        end
        S_RD: if (mem_req_ready) st <= S_RDW;
        S_RDW: if (mem_rsp_valid) begin
          if (descend) begin
            base_q <= PA_W'(ppn) << PG_W;
            lvl_q  <= lvl_q - 1'b1;
            glob_q <= glob_n;
            st     <= S_RD;
          end else if (rcode != E_NONE) begin
            st <= S_IDLE; done <= 1'b1; ok <= 1'b0; err_code <= rcode;
          end else begin
            paddr     <= {ppn | (vpn & lmask), va_q[PG_W-1:0]};
            leaf_pte  <= mem_rsp_data | (need ? PTE_W'(8'h40) : '0)
                                      | (need_d ? PTE_W'(8'h80) : '0);
            leaf_addr <= raddr;
            leaf_lvl  <= lvl_q;
            global    <= glob_n;
            if (need) st <= S_WB;
            else begin
              st <= S_IDLE; done <= 1'b1; ok <= 1'b1; err_code <= E_NONE;
            end
          end
        end
        S_WB: if (mem_req_ready) st <= S_WBW;
        S_WBW: if (mem_rsp_valid) begin
          st <= S_IDLE; done <= 1'b1;
          ok <= !mem_rsp_err;
          err_code <= mem_rsp_err ? E_ACC : E_NONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic [55:0] mem_req_addr,
  input logic [63:0] mem_req_wdata,
  input logic        done,
  input logic        ok,
  input logic [2:0]  err_code,
  input logic [63:0] leaf_pte,
  input logic [1:0]  leaf_lvl
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ok_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok == (err_code == 3'd0)));
  p_code_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> err_code <= 3'd5);
  p_wb_marks_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[6] && mem_req_wdata[0]);
  p_leaf_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && ok |-> leaf_pte[0] && (leaf_pte[1] || leaf_pte[3]) && leaf_lvl != 2'd3);
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .done(done), .ok(ok), .err_code(err_code), .leaf_pte(leaf_pte),
  .leaf_lvl(leaf_lvl)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 0, user = 0, mxr = 0, sum = 0, upd_en = 0, hold = 0;
  logic [38:0] vaddr = '0;
  logic [1:0]  acc = '0;
  logic [43:0] root_ppn = 44'h100;
  logic busy, mem_req_valid, mem_req_we, done, ok, global;
  logic [55:0] mem_req_addr, paddr, leaf_addr;
  logic [63:0] mem_req_wdata, leaf_pte;
  logic [2:0]  err_code;
  logic [1:0]  leaf_lvl;
  logic mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [63:0] mem_rsp_data = '0;
  wire mem_req_ready = !hold;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .acc(acc),
    .user(user), .mxr(mxr), .sum(sum), .upd_en(upd_en), .root_ppn(root_ppn),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data), .done(done),
    .ok(ok), .err_code(err_code), .paddr(paddr), .leaf_pte(leaf_pte),
    .leaf_addr(leaf_addr), .leaf_lvl(leaf_lvl), .global(global));

  logic [63:0] mem [logic [55:0]];
  bit err_rd [logic [55:0]];
  bit err_wr [logic [55:0]];
  logic [55:0] alog [$];
  int nwr = 0, checks = 0, fails = 0, cyc = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      alog.push_back(mem_req_addr);
      if (mem_req_we) begin
        nwr++;
        if (err_wr.exists(mem_req_addr)) mem_rsp_err <= 1'b1;
        else mem[mem_req_addr] = mem_req_wdata;
      end else if (err_rd.exists(mem_req_addr)) mem_rsp_err <= 1'b1;
      else mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'd0;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [38:0] mkva(int v2, int v1, int v0, int off);
    return {9'(v2), 9'(v1), 9'(v0), 12'(off)};
  endfunction
  function automatic logic [63:0] pte(logic [43:0] p, logic [7:0] b);
    return {10'd0, p, 2'd0, b};
  endfunction

  task automatic walk(logic [38:0] va, logic [1:0] a, logic u, logic mx,
                      logic sm, logic up);
    alog.delete(); nwr = 0;
    @(negedge clk);
    vaddr = va; acc = a; user = u; mxr = mx; sum = sm; upd_en = up; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 300 && !done; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 req", mem_req_valid, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_small_page();
    walk(mkva(1, 2, 3, 'habc), 2'd0, 0, 0, 0, 0);
    chk("R8 ok", ok, 1);
    chk("R8 paddr", paddr, 56'h12345abc);
    chk("R8 lvl", leaf_lvl, 0);
    chk("R8 leaf_addr", leaf_addr, 56'h300018);
    chk("R9 global", global, 1);
    chk("R2 reads", alog.size(), 3);
    if (alog.size() == 3) begin
      chk("R2 addr2", alog[0], 56'h100008);
      chk("R2 addr1", alog[1], 56'h200010);
      chk("R2 addr0", alog[2], 56'h300018);
    end
    chk("R11 no write", nwr, 0);
    @(negedge clk);
    chk("R13 pulse", done, 0);
  endtask

  task automatic t_super();
    walk(mkva(2, 5, 'h1ff, 'h123), 2'd3, 0, 0, 0, 0);
    chk("R8 2M code", err_code, 0);
    chk("R8 2M paddr", paddr, 56'h5ff123);
    chk("R8 2M lvl", leaf_lvl, 1);
    chk("R9 2M global", global, 0);
    walk(mkva(3, 7, 9, 'h10), 2'd0, 1, 0, 0, 0);
    chk("R8 1G paddr", paddr, 56'h40e09010);
    chk("R8 1G lvl", leaf_lvl, 2);
    chk("R2 1G reads", alog.size(), 1);
  endtask

  task automatic t_misaligned();
    walk(mkva(4, 0, 0, 0), 2'd0, 0, 0, 0, 0);
    chk("R7 misaligned", err_code, 4);
    chk("R13 ok low", ok, 0);
    walk(mkva(4, 0, 0, 0), 2'd1, 0, 0, 0, 0);
    chk("R7 perm first", err_code, 3);
  endtask

  task automatic t_invalid();
    walk(mkva(5, 0, 0, 0), 2'd0, 0, 0, 0, 0);
    chk("R5 V clear", err_code, 2);
    walk(mkva(6, 0, 0, 0), 2'd0, 0, 0, 0, 0);
    chk("R5 W no R", err_code, 2);
    walk(mkva(7, 0, 0, 0), 2'd0, 0, 0, 0, 0);
    chk("R5 ptr at 0", err_code, 2);
    chk("R5 reads", alog.size(), 3);
  endtask

  task automatic t_access_err();
    walk(mkva(8, 0, 0, 0), 2'd0, 0, 0, 0, 0);
    chk("R4 read err", err_code, 1);
  endtask

  task automatic t_perm();
    walk(mkva(3, 0, 0, 0), 2'd0, 0, 0, 0, 0);
    chk("R6 sup user page", err_code, 3);
    walk(mkva(3, 0, 0, 0), 2'd0, 0, 0, 1, 0);
    chk("R6 sum allows", err_code, 0);
    walk(mkva(3, 0, 0, 0), 2'd3, 1, 0, 0, 0);
    chk("R6 user no X", err_code, 3);
    walk(mkva(9, 0, 0, 0), 2'd0, 0, 0, 0, 0);
    chk("R6 X-only read", err_code, 3);
    walk(mkva(9, 0, 0, 0), 2'd0, 0, 1, 0, 0);
    chk("R6 mxr read", err_code, 0);
    walk(mkva(2, 5, 0, 0), 2'd3, 1, 0, 0, 0);
    chk("R6 user needs U", err_code, 3);
  endtask

  task automatic t_update();
    walk(mkva(10, 0, 0, 0), 2'd0, 0, 0, 0, 0);
    chk("R10 disabled", err_code, 5);
    chk("R10 no write", nwr, 0);
    walk(mkva(10, 0, 0, 0), 2'd1, 0, 0, 0, 1);
    chk("R11 ok", err_code, 0);
    chk("R11 writes", nwr, 1);
    chk("R11 mem", mem[56'h100050], pte(44'hc0000, 8'hc7));
    chk("R11 leaf_pte", leaf_pte, pte(44'hc0000, 8'hc7));
    walk(mkva(10, 0, 0, 0), 2'd0, 0, 0, 0, 1);
    chk("R11 clean no write", nwr, 0);
    walk(mkva(11, 0, 0, 0), 2'd0, 0, 0, 0, 1);
    chk("R12 write err", err_code, 1);
    chk("R12 write tried", nwr, 1);
  endtask

  task automatic t_stall();
    alog.delete(); nwr = 0;
    @(negedge clk);
    hold = 1; vaddr = mkva(1, 2, 3, 'h5); acc = 0; user = 0; mxr = 0; sum = 0;
    upd_en = 0; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 valid held", mem_req_valid, 1);
      chk("R3 addr held", mem_req_addr, 56'h100008);
      if (i == 1) begin vaddr = mkva(5, 0, 0, 0); start = 1; end
      else start = 0;
    end
    start = 0; hold = 0;
    for (int i = 0; i < 300 && !done; i++) @(negedge clk);
    chk("R13 start ignored", paddr, 56'h12345005);
    chk("R3 one req", alog.size(), 3);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R13 stays idle", busy, 0);
  endtask

  initial begin
    mem[56'h100008] = pte(44'h200, 8'h01);
    mem[56'h200010] = pte(44'h300, 8'h21);
    mem[56'h300018] = pte(44'h12345, 8'hc7);
    mem[56'h100010] = pte(44'h210, 8'h01);
    mem[56'h210028] = pte(44'h400, 8'h4b);
    mem[56'h100018] = pte(44'h40000, 8'h53);
    mem[56'h100020] = pte(44'h40001, 8'h43);
    mem[56'h100030] = pte(44'h0, 8'h05);
    mem[56'h100038] = pte(44'h220, 8'h01);
    mem[56'h220000] = pte(44'h230, 8'h01);
    mem[56'h230000] = pte(44'h240, 8'h01);
    mem[56'h100048] = pte(44'h80000, 8'h49);
    mem[56'h100050] = pte(44'hc0000, 8'h07);
    mem[56'h100058] = pte(44'h100000, 8'h03);
    err_rd[56'h100040] = 1;
    err_wr[56'h100058] = 1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_small_page();
    t_super();
    t_misaligned();
    t_invalid();
    t_access_err();
    t_perm();
    t_update();
    t_stall();
    summary();
  end
endmodule